// File: doc/BRIEF.md
# Accumulator Machine Instruction-Cycle Sequencer

This block is the control sequencer and register datapath of a small accumulator machine. It holds the program counter, memory address register, memory data register, instruction register and accumulator. It walks each instruction through its fetch, optional indirect, execute and optional interrupt phases. Each clock performs one group of register transfers, called a slot. Program and data live in one single-port synchronous RAM outside the block, so no slot ever carries both a read and a write.

The RAM samples its address and write enable on every rising edge and returns read data one cycle later. To make this work, the block drives the address from the value its address register is being loaded with. The RAM therefore captures an address in the same slot the address register is loaded, and the data word can move into the data register in the next slot.

Two inputs control interrupts: a level interrupt request and a one-cycle pulse that arms the interrupt enable. A four-bit slot code, the program counter, the accumulator and a halted flag are brought out so that an outside model can follow the machine one slot at a time.

Top module: `acc_seq_core`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the slot code is 0, PC is 0, AC is 0, halted is 0 and the interrupt enable is clear.
- R2: Fetch takes three slots, with codes 0, 1 and 2. In slot 0 the address register is loaded from PC and the RAM sees PC as the address. In slot 1 the RAM word is captured into the data register and PC increases by 1. In slot 2 the data register is copied into IR.
- R3: A write occurs only in slot 8 of a store and in slot 11 of interrupt entry. No slot both captures a read word and writes memory.
- R4: An instruction word has three fields. Bit 15 is the indirect flag, bits 14:12 are the opcode and bits 11:0 are the address. The opcodes are 0 AND, 1 ADD, 2 LDA, 3 STA, 4 branch and 5 halt; 6 and 7 do nothing for one execute slot.
- R5: For opcodes 0 to 4 with bit 15 set, three slots with codes 3, 4 and 5 run between fetch and execute. They replace IR bits 11:0 with bits 11:0 of the word at the old address. For opcodes 5 to 7, bit 15 has no effect.
- R6: AND, ADD and LDA each execute in slots 6, 7 and 8. The result loaded into AC is AC & M, (AC + M) mod 2^16, or M, where M is the operand word.
- R7: STA executes in slots 6, 7 and 8 and writes AC to the operand address in slot 8.
- R8: Branch executes in slot 6 alone. The next fetch starts at the address field.
- R9: Halt executes in slot 6 and then enters slot 12. In slot 12 halted is 1, PC is frozen, nothing is written and the interrupt request is ignored, until reset.
- R10: After the last execute slot, interrupt entry runs only if the enable is set and the request is high; otherwise fetch follows. Interrupt entry runs slots 9, 10 and 11. Slot 9 copies PC into the data register and clears the enable. Slot 10 loads address 0 into the address register and 1 into PC. Slot 11 writes the saved PC to address 0. A pulse on ien_set arms the enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Interrupt request level |
| ien_set | input | 1 | One-cycle pulse that arms the interrupt enable |
| mem_addr | output | 12 | RAM address, sampled by the RAM on each rising edge |
| mem_wdata | output | 16 | RAM write data (data register) |
| mem_we | output | 1 | RAM write enable |
| mem_rdata | input | 16 | RAM read data, valid one cycle after the address |
| halted | output | 1 | High while the machine is stopped |
| state_o | output | 4 | Current slot code |
| pc_o | output | 12 | Program counter |
| ac_o | output | 16 | Accumulator |

## Verification
Several behaviours are checked by the assertions on every cycle. These are the slot order within fetch, the PC step and the data-register-to-IR transfer, the indirect address replacement, the restriction of writes to the two write slots, and the save address and vector at interrupt entry. They also check that interrupt entry happens only with the enable armed and a request present, that the enable is clear after entry, and that halt is sticky. The bench scenarios are needed for the rest: the whole slot sequence and PC of a program, accumulator results including ADD wrap-around, and store targets reached through an indirect word. They also show a return from the service routine through an indirect branch on the saved word, a request that is ignored while the enable is clear or the machine is halted, and an indirect flag that has no effect on halt.

// File: rtl/acc_seq_pkg.sv
`timescale 1ns/1ps
package acc_seq_pkg;

  localparam int OP_W = 3;
  localparam int ST_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'd0,
    OP_ADD = 3'd1,
    OP_LDA = 3'd2,
    OP_STA = 3'd3,
    OP_BUN = 3'd4,
    OP_HLT = 3'd5,
    OP_NO6 = 3'd6,
    OP_NO7 = 3'd7
  } op_t;

  typedef enum logic [ST_W-1:0] {
    S_F0  = 4'd0,
    S_F1  = 4'd1,
    S_F2  = 4'd2,
    S_I0  = 4'd3,
    S_I1  = 4'd4,
    S_I2  = 4'd5,
    S_E0  = 4'd6,
    S_E1  = 4'd7,
    S_E2  = 4'd8,
    S_N0  = 4'd9,
    S_N1  = 4'd10,
    S_N2  = 4'd11,
    S_HLT = 4'd12
  } slot_t;

  // One strobe per register transfer the datapath can perform.
  typedef struct packed {
    logic mar_pc;
    logic mar_ir;
    logic mar_save;
    logic mdr_mem;
    logic mdr_ac;
    logic mdr_pc;
    logic ir_all;
    logic ir_addr;
    logic pc_inc;
    logic pc_ir;
    logic pc_vec;
    logic ac_ld;
    logic mem_wr;
    logic ien_clr;
  } ctl_t;

  // Opcodes that name a memory operand and so may go through the indirect cycle.
  function automatic logic takes_operand(op_t op);
    return (op == OP_AND) || (op == OP_ADD) || (op == OP_LDA) ||
           (op == OP_STA) || (op == OP_BUN);
  endfunction

endpackage

// File: rtl/acc_seq_alu.sv
`timescale 1ns/1ps
module acc_seq_alu
  import acc_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  op_t               op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] y
);

  function automatic logic [DATA_W-1:0] alu_eval(op_t f, logic [DATA_W-1:0] a,
                                                 logic [DATA_W-1:0] b);
    case (f)
      OP_AND:  return a & b;
      OP_ADD:  return a + b;
      OP_LDA:  return b;
      default: return a;
    endcase
  endfunction

  assign y = alu_eval(op, acc, opnd);

endmodule

// File: rtl/acc_seq_ctrl.sv
`timescale 1ns/1ps
module acc_seq_ctrl
  import acc_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ir_ind,
  input  op_t   ir_op,
  input  logic  nx_ind,
  input  op_t   nx_op,
  input  logic  irq,
  input  logic  ien_set,
  output ctl_t  ctl,
  output slot_t st,
  output logic  halted
);

  slot_t st_d;
  logic  ien_q;
  logic  irq_take;
  slot_t after_exec;

  assign irq_take   = ien_q && irq;
  assign after_exec = irq_take ? S_N0 : S_F0;

  always_comb begin
    ctl  = '0;
    st_d = st;
    case (st)
      S_F0: begin ctl.mar_pc = 1'b1; st_d = S_F1; end
      S_F1: begin ctl.mdr_mem = 1'b1; ctl.pc_inc = 1'b1; st_d = S_F2; end
      S_F2: begin
        ctl.ir_all = 1'b1;
        st_d = (nx_ind && takes_operand(nx_op)) ? S_I0 : S_E0;
      end
      S_I0: begin ctl.mar_ir = 1'b1; st_d = S_I1; end
      S_I1: begin ctl.mdr_mem = 1'b1; st_d = S_I2; end
      S_I2: begin ctl.ir_addr = 1'b1; st_d = S_E0; end
      S_E0: begin
        case (ir_op)
          OP_AND, OP_ADD, OP_LDA, OP_STA: begin ctl.mar_ir = 1'b1; st_d = S_E1; end
          OP_BUN:  begin ctl.pc_ir = 1'b1; st_d = after_exec; end
          OP_HLT:  st_d = S_HLT;
          default: st_d = after_exec;
        endcase
      end
      S_E1: begin
        if (ir_op == OP_STA) ctl.mdr_ac = 1'b1;
        else                 ctl.mdr_mem = 1'b1;
        st_d = S_E2;
      end
      S_E2: begin
        if (ir_op == OP_STA) ctl.mem_wr = 1'b1;
        else                 ctl.ac_ld = 1'b1;
        st_d = after_exec;
      end
      S_N0: begin ctl.mdr_pc = 1'b1; ctl.ien_clr = 1'b1; st_d = S_N1; end
      S_N1: begin ctl.mar_save = 1'b1; ctl.pc_vec = 1'b1; st_d = S_N2; end
      S_N2: begin ctl.mem_wr = 1'b1; st_d = S_F0; end
      default: st_d = S_HLT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_F0;
      ien_q <= 1'b0;
    end else begin
      st <= st_d;
      if (ctl.ien_clr)  ien_q <= 1'b0;
      else if (ien_set) ien_q <= 1'b1;
    end
  end

  assign halted = (st == S_HLT);

  // R2: the IR load slot always follows the capture slot of fetch
  a_r2_fetch_order: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_F2) |-> ($past(st) == S_F1));

  // R10: interrupt entry only with the enable armed and a request present
  a_r10_entry_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_N0) |-> ($past(ien_q) && $past(irq)));

  // R10: enable is clear once entry has begun
  a_r10_ien_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_N0) |=> !ien_q);

  // R9: halt persists until reset
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

endmodule

// File: rtl/acc_seq_dp.sv
`timescale 1ns/1ps
module acc_seq_dp
  import acc_seq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int SAVE_ADDR = 0,
  parameter int VEC_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] alu_y,
  output logic [ADDR_W-1:0] mar_d,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] mdr,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] ac
);

  localparam int PAD_W = DATA_W - ADDR_W;
  localparam logic [ADDR_W-1:0] SAVE_A = ADDR_W'(SAVE_ADDR);
  localparam logic [ADDR_W-1:0] VEC_A  = ADDR_W'(VEC_ADDR);

  logic [ADDR_W-1:0] mar;
  logic [ADDR_W-1:0] ir_field;

  assign ir_field = ir[ADDR_W-1:0];

  // The RAM is addressed by the value the address register takes this slot.
  always_comb begin
    if (ctl.mar_pc)        mar_d = pc;
    else if (ctl.mar_ir)   mar_d = ir_field;
    else if (ctl.mar_save) mar_d = SAVE_A;
    else                   mar_d = mar;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar <= '0;
      pc  <= '0;
      mdr <= '0;
      ir  <= '0;
      ac  <= '0;
    end else begin
      mar <= mar_d;
      if (ctl.mdr_mem)     mdr <= mem_rdata;
      else if (ctl.mdr_ac) mdr <= ac;
      else if (ctl.mdr_pc) mdr <= {{PAD_W{1'b0}}, pc};
      if (ctl.ir_all)       ir <= mdr;
      else if (ctl.ir_addr) ir <= {ir[DATA_W-1:ADDR_W], mdr[ADDR_W-1:0]};
      if (ctl.pc_inc)      pc <= pc + 1'b1;
      else if (ctl.pc_ir)  pc <= ir_field;
      else if (ctl.pc_vec) pc <= VEC_A;
      if (ctl.ac_ld) ac <= alu_y;
    end
  end

  // R2: PC advances by exactly one in the fetch capture slot
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.pc_inc |=> (pc == ADDR_W'($past(pc) + 1'b1)));

  // R2: IR receives the captured word
  a_r2_ir_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ir_all |=> (ir == $past(mdr)));

  // R5: indirect cycle swaps only the address field
  a_r5_direct_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ir_addr |=> ((ir[ADDR_W-1:0] == $past(mdr[ADDR_W-1:0])) &&
                     (ir[DATA_W-1:ADDR_W] == $past(ir[DATA_W-1:ADDR_W]))));

  // R10: vector and save address loaded together
  a_r10_vector: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.pc_vec |=> ((pc == VEC_A) && (mar == SAVE_A)));

endmodule

// File: rtl/acc_seq_core.sv
`timescale 1ns/1ps
module acc_seq_core
  import acc_seq_pkg::*;
#(
  parameter int   ADDR_W    = 12,
  parameter int   SAVE_ADDR = 0,
  parameter int   VEC_ADDR  = 1,
  localparam int  DATA_W    = 1 + OP_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  input  logic              ien_set,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted,
  output logic [ST_W-1:0]   state_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ac_o
);

  localparam int IND_BIT = DATA_W - 1;
  localparam int OP_LSB  = ADDR_W;

  ctl_t              ctl;
  slot_t             st;
  logic [DATA_W-1:0] mdr, ir, ac, alu_y;
  op_t               ir_op, nx_op;

  assign ir_op = op_t'(ir[OP_LSB +: OP_W]);
  assign nx_op = op_t'(mdr[OP_LSB +: OP_W]);

  acc_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ir_ind  (ir[IND_BIT]),
    .ir_op   (ir_op),
    .nx_ind  (mdr[IND_BIT]),
    .nx_op   (nx_op),
    .irq     (irq),
    .ien_set (ien_set),
    .ctl     (ctl),
    .st      (st),
    .halted  (halted)
  );

  acc_seq_dp #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .SAVE_ADDR (SAVE_ADDR),
    .VEC_ADDR  (VEC_ADDR)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .alu_y     (alu_y),
    .mar_d     (mem_addr),
    .pc        (pc_o),
    .mdr       (mdr),
    .ir        (ir),
    .ac        (ac)
  );

  acc_seq_alu #(.DATA_W(DATA_W)) u_alu (
    .op   (ir_op),
    .acc  (ac),
    .opnd (mdr),
    .y    (alu_y)
  );

  assign mem_wdata = mdr;
  assign mem_we    = ctl.mem_wr;
  assign state_o   = st;
  assign ac_o      = ac;

  // R3: writes only in the store slot or the save slot
  a_r3_write_slot: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((state_o == S_E2) || (state_o == S_N2)));

  // R10: the save slot writes to the fixed save address
  a_r10_save_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_N2) |-> (mem_we && (mem_addr == ADDR_W'(SAVE_ADDR))));

endmodule

// File: tb/sim_acc_seq_core.sv
`timescale 1ns/1ps
module sim_acc_seq_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic        ien_set = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata;
  logic        halted;
  logic [3:0]  state_o;
  logic [11:0] pc_o;
  logic [15:0] ac_o;

  always #2.5 clk = ~clk;

  acc_seq_core u0 (
    .clk(clk), .rst_n(rst_n), .irq(irq), .ien_set(ien_set),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .halted(halted), .state_o(state_o),
    .pc_o(pc_o), .ac_o(ac_o)
  );

  // Synchronous single-port RAM model
  logic [15:0] ram [0:255];
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= ram[mem_addr[7:0]];
  end

  typedef struct {
    logic [3:0]  st;
    logic [11:0] pc;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int    vectors = 0;
  int    fails = 0;
  logic  mon_on = 1'b0;
  logic  done = 1'b0;

  // Monitor: one expected slot per cycle, sampled mid-cycle
  always @(negedge clk) begin
    if (mon_on && exp_q.size() != 0) begin
      item_t it;
      it = exp_q.pop_front();
      vectors++;
      if (state_o !== it.st || pc_o !== it.pc) begin
        fails++;
        $display("FAIL %s slot/pc: actual st=%0d pc=%h expected st=%0d pc=%h",
                 it.tag, state_o, pc_o, it.st, it.pc);
      end
    end
  end

  task automatic push(input logic [3:0] s, input logic [11:0] p, input string tag);
    item_t it;
    it.st = s; it.pc = p; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic exp_fetch(input logic [11:0] a);
    push(4'd0, a, "R2"); push(4'd1, a, "R2"); push(4'd2, a + 12'd1, "R2");
  endtask

  task automatic exp_ind(input logic [11:0] p);
    push(4'd3, p, "R5"); push(4'd4, p, "R5"); push(4'd5, p, "R5");
  endtask

  task automatic exp_mem(input logic [11:0] p, input string tag);
    push(4'd6, p, tag); push(4'd7, p, tag); push(4'd8, p, tag);
  endtask

  task automatic exp_irq(input logic [11:0] ret);
    push(4'd9, ret, "R10"); push(4'd10, ret, "R10"); push(4'd11, 12'd1, "R10");
  endtask

  task automatic exp_halt(input logic [11:0] p, input int n);
    push(4'd6, p, "R9");
    for (int k = 0; k < n; k++) push(4'd12, p, "R9");
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic begin_phase(input logic irq_lvl);
    @(posedge clk); #1;
    rst_n = 1'b0; mon_on = 1'b0; ien_set = 1'b0; irq = irq_lvl;
    @(negedge clk);
    chk("R1 slot", {12'd0, state_o}, 16'd0);
    chk("R1 pc", {4'd0, pc_o}, 16'd0);
    chk("R1 ac", ac_o, 16'd0);
    chk("R1 halted", {15'd0, halted}, 16'd0);
    for (int k = 0; k < 256; k++) ram[k] = 16'h0000;
  endtask

  task automatic run_phase(input logic arm);
    @(posedge clk); #1;
    rst_n = 1'b1; ien_set = arm; mon_on = 1'b1;
    @(posedge clk); #1;
    ien_set = 1'b0;
    wait (exp_q.size() == 0);
    @(negedge clk);
    mon_on = 1'b0;
  endtask

  initial begin
    // Phase A: direct and indirect operands, request held high but enable never armed
    begin_phase(1'b1);
    ram[8'h00] = 16'h2020; ram[8'h01] = 16'h1021; ram[8'h02] = 16'h3030;
    ram[8'h03] = 16'h0022; ram[8'h04] = 16'h4006; ram[8'h05] = 16'h2023;
    ram[8'h06] = 16'h9024; ram[8'h07] = 16'hB025; ram[8'h08] = 16'h6000;
    ram[8'h09] = 16'h5000;
    ram[8'h20] = 16'h1234; ram[8'h21] = 16'h0F0F; ram[8'h22] = 16'hFF00;
    ram[8'h23] = 16'hDEAD; ram[8'h24] = 16'h0021; ram[8'h25] = 16'h0031;
    exp_fetch(12'h000); exp_mem(12'h001, "R6");
    exp_fetch(12'h001); exp_mem(12'h002, "R6");
    exp_fetch(12'h002); exp_mem(12'h003, "R7");
    exp_fetch(12'h003); exp_mem(12'h004, "R6");
    exp_fetch(12'h004); push(4'd6, 12'h005, "R8");
    exp_fetch(12'h006); exp_ind(12'h007); exp_mem(12'h007, "R6");
    exp_fetch(12'h007); exp_ind(12'h008); exp_mem(12'h008, "R7");
    exp_fetch(12'h008); push(4'd6, 12'h009, "R4");
    exp_fetch(12'h009); exp_halt(12'h00A, 6);
    run_phase(1'b0);
    chk("R6 ac after and/add/indirect add", ac_o, 16'h300F);
    chk("R7 direct store", ram[8'h30], 16'h2143);
    chk("R7 indirect store", ram[8'h31], 16'h300F);
    chk("R8 skipped word not loaded", ram[8'h23], 16'hDEAD);
    chk("R9 halted flag", {15'd0, halted}, 16'd1);
    chk("R10 no save without enable", ram[8'h00], 16'h2020);

    // Phase B: interrupt entry, service, indirect return, halt ignores request
    begin_phase(1'b1);
    ram[8'h00] = 16'h4010; ram[8'h01] = 16'h2040; ram[8'h02] = 16'hC000;
    ram[8'h10] = 16'h3041; ram[8'h11] = 16'h5000; ram[8'h40] = 16'h5A5A;
    exp_fetch(12'h000); push(4'd6, 12'h001, "R8"); exp_irq(12'h010);
    exp_fetch(12'h001); exp_mem(12'h002, "R6");
    exp_fetch(12'h002); exp_ind(12'h003); push(4'd6, 12'h003, "R8");
    exp_fetch(12'h010); exp_mem(12'h011, "R7");
    exp_fetch(12'h011); exp_halt(12'h012, 8);
    run_phase(1'b1);
    chk("R10 saved return pc", ram[8'h00], 16'h0010);
    chk("R7 store in service return path", ram[8'h41], 16'h5A5A);
    chk("R6 lda", ac_o, 16'h5A5A);
    chk("R9 halted with request high", {15'd0, halted}, 16'd1);

    // Phase C: add wraps, indirect flag on halt ignored, enable armed without request
    begin_phase(1'b0);
    ram[8'h00] = 16'h2008; ram[8'h01] = 16'h1009; ram[8'h02] = 16'hD000;
    ram[8'h08] = 16'hFFFF; ram[8'h09] = 16'h0003;
    exp_fetch(12'h000); exp_mem(12'h001, "R6");
    exp_fetch(12'h001); exp_mem(12'h002, "R6");
    exp_fetch(12'h002); exp_halt(12'h003, 4);
    run_phase(1'b1);
    chk("R6 add wraps", ac_o, 16'h0002);
    chk("R5 halt word unchanged", ram[8'h02], 16'hD000);
    chk("R3 no stray write at 0", ram[8'h00], 16'h2008);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule